// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This unit carries out one read-modify-write operation on a memory word as a single, uninterrupted sequence. A decoded operation comes in with a one-byte selector, a size flag, the low address bits of the destination register, a signed offset, the source register value and the value of R0. The unit adds the offset to the base to form the address. It takes the memory lock and reads the old value. It spends one cycle on evaluation, writes the new value when one is due, and then releases the lock.

The supported operations are add, or, and, xor, exchange and compare-and-exchange. Each can work on a 32-bit word or a 64-bit double word. In the result cycle the unit can hand back the pre-update memory value for the source register. For compare-and-exchange it also hands back that value for R0. The memory side is a request/acknowledge port with a size flag and a lock line. The lock is held high from the read until the write has completed.

Top module: `amo_engine`

## Requirements
- R1: The memory address equals `dst_base` plus `op_offset` sign-extended to the address width, wrapping modulo 2^ADDR_W.
- R2: The operation is chosen by `op_imm[7:4]`: 0x0 add, 0x4 or, 0x5 and, 0xa xor, 0xe exchange, 0xf compare-and-exchange. For the first four, memory is written with the result of applying the operation to the old memory value and the source value.
- R3: Bit `op_imm[0]` requests a fetch. When it is set, `src_wr` is high in the done cycle and `src_wdata` carries the memory value from before the update. When it is clear for add/or/and/xor, `src_wr` stays low. Exchange and compare-and-exchange always fetch.
- R4: Exchange writes the source value to memory and returns the old memory value on `src_wdata`.
- R5: Compare-and-exchange writes the source value only when the old memory value equals R0. On a mismatch it issues no write request at all.
- R6: Compare-and-exchange raises `r0_wr` in the done cycle, with `r0_wdata` set to the old value, whether or not the compare matched. No other operation raises `r0_wr`.
- R7: With `op_dword`=0 only the low 32 bits of the source, R0 and `mem_rdata` are used. Arithmetic wraps modulo 2^32, and `mem_wdata`, `src_wdata` and `r0_wdata` have zero upper halves. With `op_dword`=1 all 64 bits are used.
- R8: Each sequence is a read request, then one evaluation cycle, then an optional write request. `mem_lock` is high whenever a request is raised. A request holds its address and direction until `mem_ack`.
- R9: `op_ready` is low from acceptance until the cycle after the one-cycle `done` pulse, so no second operation can be accepted mid-sequence.
- R10: An operation whose code is not listed in R2, or whose `op_imm[3:1]` is nonzero, is consumed with no memory request and no `done`, and `op_ready` stays high.
- R11: After reset `op_ready` is high and `mem_req`, `mem_lock` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation taken when valid |
| op_imm | input | IMM_W | Operation selector and fetch bit |
| op_dword | input | 1 | 1 = 64-bit access, 0 = 32-bit |
| dst_base | input | ADDR_W | Destination register value (address bits) |
| op_offset | input | OFF_W | Signed address offset |
| src_val | input | DATA_W | Source register value |
| r0_val | input | DATA_W | R0 value (compare operand) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_lock | output | 1 | Memory lock held |
| mem_dword | output | 1 | Access size of the request |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | DATA_W | Read data, valid with the read acknowledge |
| done | output | 1 | Sequence finished, results valid |
| src_wr | output | 1 | Write fetched value to source register |
| src_wdata | output | DATA_W | Fetched old value |
| r0_wr | output | 1 | Write R0 |
| r0_wdata | output | DATA_W | Zero-extended old value for R0 |

## Verification
The bench uses the default parameters: 64-bit data, a 32-bit address, a 16-bit offset and an 8-bit selector. The data width lets both access sizes run through the same datapath. The 16-bit offset makes negative displacements and address wrap reachable. The bench's memory model decodes address bits 6 to 3 as the double-word index and bit 2 as the half. This lets random addresses collide, so every operation keeps acting on values left behind by earlier ones. Word reads return junk in the upper half of `mem_rdata`, so a failure to mask the operands shows up.

// File: rtl/amo_pkg.sv
package amo_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_OR   = 4'h4,
    OP_AND  = 4'h5,
    OP_XOR  = 4'ha,
    OP_SWAP = 4'he,
    OP_CAS  = 4'hf
  } amo_code_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_EVAL,
    ST_WRITE,
    ST_FIN
  } amo_state_e;

  function automatic logic code_known(input logic [3:0] c);
    case (c)
      OP_ADD, OP_OR, OP_AND, OP_XOR, OP_SWAP, OP_CAS: return 1'b1;
      default:                                        return 1'b0;
    endcase
  endfunction

  function automatic logic code_forces_fetch(input logic [3:0] c);
    return (c == OP_SWAP) || (c == OP_CAS);
  endfunction

endpackage

// File: rtl/amo_addr_gen.sv
module amo_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] off_ext;

  generate
    if (OFF_W < ADDR_W) begin : g_sext
      assign off_ext = {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
    end else begin : g_trunc
      assign off_ext = offset[ADDR_W-1:0];
    end
  endgenerate

  assign addr = base + off_ext;
endmodule

// File: rtl/amo_alu.sv
module amo_alu import amo_pkg::*; #(
  parameter int DATA_W = 64
) (
  input  logic [3:0]        code,
  input  logic              dword,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] r0_val,
  output logic [DATA_W-1:0] new_val,
  output logic              cmp_hit,
  output logic              need_write
);
  localparam int HALF_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] narrow(input logic [DATA_W-1:0] v, input logic wide);
    return wide ? v : {{HALF_W{1'b0}}, v[HALF_W-1:0]};
  endfunction

  function automatic logic [DATA_W-1:0] combine(input logic [3:0] c,
                                                input logic [DATA_W-1:0] m,
                                                input logic [DATA_W-1:0] s);
    case (c)
      OP_ADD:          return m + s;
      OP_OR:           return m | s;
      OP_AND:          return m & s;
      OP_XOR:          return m ^ s;
      OP_SWAP, OP_CAS: return s;
      default:         return m;
    endcase
  endfunction

  logic [DATA_W-1:0] old_n, src_n, r0_n;

  always_comb begin
    old_n      = narrow(old_val, dword);
    src_n      = narrow(src_val, dword);
    r0_n       = narrow(r0_val, dword);
    cmp_hit    = (code == OP_CAS) && (old_n == r0_n);
    new_val    = narrow(combine(code, old_n, src_n), dword);
    need_write = (code != OP_CAS) || cmp_hit;
  end
endmodule

// File: rtl/amo_seq.sv
module amo_seq import amo_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       mem_ack,
  input  logic       need_write,
  output amo_state_e state,
  output logic       rd_fire,
  output logic       wr_fire
);
  amo_state_e nxt;

  assign rd_fire = (state == ST_READ)  && mem_ack;
  assign wr_fire = (state == ST_WRITE) && mem_ack;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (start) nxt = ST_READ;
      ST_READ:  if (mem_ack) nxt = ST_EVAL;
      ST_EVAL:  nxt = need_write ? ST_WRITE : ST_FIN;
      ST_WRITE: if (mem_ack) nxt = ST_FIN;
      ST_FIN:   nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/amo_engine.sv
module amo_engine import amo_pkg::*; #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [IMM_W-1:0]  op_imm,
  input  logic              op_dword,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [OFF_W-1:0]  op_offset,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] r0_val,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_lock,
  output logic              mem_dword,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              src_wr,
  output logic [DATA_W-1:0] src_wdata,
  output logic              r0_wr,
  output logic [DATA_W-1:0] r0_wdata
);
  localparam int HALF_W = DATA_W / 2;

  logic [3:0]        op_code;
  logic              code_ok;
  logic              start;
  logic [ADDR_W-1:0] ea;

  logic [3:0]        code_q;
  logic              dword_q, fetch_q, cas_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] src_q, r0_q, old_q;

  amo_state_e        state;
  logic              rd_fire, wr_fire;
  logic [DATA_W-1:0] new_val;
  logic              cmp_hit, need_write;

  assign op_code  = op_imm[IMM_W-1 -: 4];
  assign code_ok  = code_known(op_code) && (op_imm[IMM_W-5:1] == '0);
  assign op_ready = (state == ST_IDLE);
  assign start    = op_valid && op_ready && code_ok;

  amo_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .base   (dst_base),
    .offset (op_offset),
    .addr   (ea)
  );

  amo_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mem_ack    (mem_ack),
    .need_write (need_write),
    .state      (state),
    .rd_fire    (rd_fire),
    .wr_fire    (wr_fire)
  );

  amo_alu #(.DATA_W(DATA_W)) u_alu (
    .code       (code_q),
    .dword      (dword_q),
    .old_val    (old_q),
    .src_val    (src_q),
    .r0_val     (r0_q),
    .new_val    (new_val),
    .cmp_hit    (cmp_hit),
    .need_write (need_write)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q  <= '0;
      dword_q <= 1'b0;
      fetch_q <= 1'b0;
      cas_q   <= 1'b0;
      addr_q  <= '0;
      src_q   <= '0;
      r0_q    <= '0;
      old_q   <= '0;
    end else begin
      if (start) begin
        code_q  <= op_code;
        dword_q <= op_dword;
        fetch_q <= op_imm[0] || code_forces_fetch(op_code);
        cas_q   <= (op_code == OP_CAS);
        addr_q  <= ea;
        src_q   <= src_val;
        r0_q    <= r0_val;
      end
      if (rd_fire)
        old_q <= dword_q ? mem_rdata : {{HALF_W{1'b0}}, mem_rdata[HALF_W-1:0]};
    end
  end

  assign mem_req   = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we    = (state == ST_WRITE);
  assign mem_lock  = (state == ST_READ) || (state == ST_EVAL) || (state == ST_WRITE);
  assign mem_dword = dword_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = new_val;

  assign done      = (state == ST_FIN);
  assign src_wr    = done && fetch_q;
  assign src_wdata = old_q;
  assign r0_wr     = done && cas_q;
  assign r0_wdata  = old_q;
endmodule

// File: rtl/amo_engine_chk.sv
module amo_engine_chk #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_ready,
  input logic              code_ok,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic              mem_lock,
  input logic              mem_dword,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              done,
  input logic [DATA_W-1:0] src_wdata,
  input logic              r0_wr,
  input logic [DATA_W-1:0] r0_wdata,
  input logic              wr_fire,
  input logic              cmp_hit,
  input logic              cas_q,
  input logic              dword_q
);
  localparam int HALF_W = DATA_W / 2;

  // R8
  lock_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_lock);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R5
  cas_miss_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> !(cas_q && !cmp_hit));

  // R6
  r0_only_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r0_wr |-> done && cas_q);

  // R7
  word_result_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !dword_q |-> (src_wdata[DATA_W-1:HALF_W] == '0) && (r0_wdata[DATA_W-1:HALF_W] == '0));

  // R7
  word_wdata_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !mem_dword |-> mem_wdata[DATA_W-1:HALF_W] == '0);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && op_ready);

  // R9
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_lock) |-> !op_ready);

  // R10
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_ready && !code_ok |=> !mem_req && op_ready);
endmodule

bind amo_engine amo_engine_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_ready  (op_ready),
  .code_ok   (code_ok),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_lock  (mem_lock),
  .mem_dword (mem_dword),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .done      (done),
  .src_wdata (src_wdata),
  .r0_wr     (r0_wr),
  .r0_wdata  (r0_wdata),
  .wr_fire   (wr_fire),
  .cmp_hit   (cmp_hit),
  .cas_q     (cas_q),
  .dword_q   (dword_q)
);

// File: tb/amo_engine_test.sv
module amo_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [7:0]  op_imm = '0;
  logic        op_dword = 1'b0;
  logic [31:0] dst_base = '0;
  logic [15:0] op_offset = '0;
  logic [63:0] src_val = '0;
  logic [63:0] r0_val = '0;
  logic        mem_req, mem_we, mem_lock, mem_dword;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        done, src_wr, r0_wr;
  logic [63:0] src_wdata, r0_wdata;

  always #4 clk = ~clk;

  amo_engine uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_imm(op_imm), .op_dword(op_dword), .dst_base(dst_base), .op_offset(op_offset),
    .src_val(src_val), .r0_val(r0_val), .mem_req(mem_req), .mem_we(mem_we),
    .mem_lock(mem_lock), .mem_dword(mem_dword), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .src_wr(src_wr),
    .src_wdata(src_wdata), .r0_wr(r0_wr), .r0_wdata(r0_wdata)
  );

  int checks = 0;
  int fails  = 0;
  logic [63:0] mem_m [16];
  int wr_count = 0;
  int rd_count = 0;
  int lock_bad = 0;
  int wzext_bad = 0;
  logic [31:0] rd_addr_seen = '0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] lo32(input logic [63:0] v);
    return {32'h0, v[31:0]};
  endfunction

  // independent model of the operation
  function automatic void model_op(input logic [3:0] c, input bit dw, input logic [63:0] old,
                                   input logic [63:0] s, input logic [63:0] r,
                                   output logic [63:0] nv, output bit wr);
    logic [63:0] a, b, rr;
    a  = dw ? old : lo32(old);
    b  = dw ? s   : lo32(s);
    rr = dw ? r   : lo32(r);
    wr = 1;
    case (c)
      4'h0: nv = a + b;
      4'h4: nv = a | b;
      4'h5: nv = a & b;
      4'ha: nv = a ^ b;
      4'he: nv = b;
      default: begin nv = b; wr = (a == rr); end
    endcase
    if (!dw) nv = lo32(nv);
  endfunction

  // memory responder
  initial begin : responder
    int lat;
    int idx;
    lat = 0;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_lock) lock_bad++;
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (lat > 0) lat--;
        else begin
          idx = int'(mem_addr[6:3]);
          if (mem_we) begin
            wr_count++;
            if (mem_dword) mem_m[idx] = mem_wdata;
            else begin
              if (mem_wdata[63:32] != 0) wzext_bad++;
              if (mem_addr[2]) mem_m[idx][63:32] = mem_wdata[31:0];
              else             mem_m[idx][31:0]  = mem_wdata[31:0];
            end
          end else begin
            rd_count++;
            rd_addr_seen = mem_addr;
            if (mem_dword) mem_rdata = mem_m[idx];
            else mem_rdata = {$urandom(), (mem_addr[2] ? mem_m[idx][63:32] : mem_m[idx][31:0])};
          end
          mem_ack = 1'b1;
          lat = int'($urandom() % 3);
        end
      end
    end
  end

  task automatic run_op(input logic [7:0] imm, input bit dw, input logic [31:0] dst,
                        input logic [15:0] off, input logic [63:0] s, input logic [63:0] r);
    logic [31:0] ea;
    int idx;
    logic [63:0] old, nv, exp_word;
    bit wr, fetch, is_cas, busy_bad;
    int n;
    ea = dst + {{16{off[15]}}, off};
    idx = int'(ea[6:3]);
    old = dw ? mem_m[idx] : (ea[2] ? {32'h0, mem_m[idx][63:32]} : {32'h0, mem_m[idx][31:0]});
    model_op(imm[7:4], dw, old, s, r, nv, wr);
    fetch  = imm[0] || imm[7:4] == 4'he || imm[7:4] == 4'hf;
    is_cas = (imm[7:4] == 4'hf);
    exp_word = mem_m[idx];
    if (wr) begin
      if (dw) exp_word = nv;
      else if (ea[2]) exp_word[63:32] = nv[31:0];
      else exp_word[31:0] = nv[31:0];
    end
    wr_count = 0;
    rd_count = 0;
    op_imm = imm; op_dword = dw; dst_base = dst; op_offset = off; src_val = s; r0_val = r;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    busy_bad = 0;
    n = 0;
    while (!done && n < 60) begin
      if (op_ready) busy_bad = 1;
      @(negedge clk);
      n++;
    end
    chk(done, "R8 sequence completes", {63'h0, done}, 64'h1);
    chk(!busy_bad, "R9 ready low while busy", {63'h0, busy_bad}, 64'h0);
    chk(rd_addr_seen == ea, "R1 address", {32'h0, rd_addr_seen}, {32'h0, ea});
    chk(src_wr == fetch, "R3 fetch strobe", {63'h0, src_wr}, {63'h0, fetch});
    if (fetch) chk(src_wdata == old, "R3/R4 fetched old value", src_wdata, old);
    chk(r0_wr == is_cas, "R6 r0 strobe", {63'h0, r0_wr}, {63'h0, is_cas});
    if (is_cas) chk(r0_wdata == old, "R6 r0 old value", r0_wdata, old);
    chk(wr_count == (wr ? 1 : 0), is_cas ? "R5 cas write count" : "R2 write count",
        64'(wr_count), wr ? 64'h1 : 64'h0);
    chk(mem_m[idx] == exp_word, dw ? "R2 memory result" : "R7 word memory result", mem_m[idx], exp_word);
    @(negedge clk);
    chk(op_ready && !done, "R9 ready after done", {62'h0, op_ready, done}, 64'h2);
  endtask

  task automatic reject_op(input logic [7:0] imm);
    bit seen;
    seen = 0;
    op_imm = imm; op_dword = 1'b1; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    for (int k = 0; k < 6; k++) begin
      if (mem_req || done || !op_ready) seen = 1;
      @(negedge clk);
    end
    chk(!seen, "R10 unsupported op ignored", {63'h0, seen}, 64'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [3:0] codes [6];
    void'($urandom(32'h5eed_1234));
    codes[0] = 4'h0; codes[1] = 4'h4; codes[2] = 4'h5;
    codes[3] = 4'ha; codes[4] = 4'he; codes[5] = 4'hf;
    for (int i = 0; i < 16; i++) mem_m[i] = {$urandom(), $urandom()};
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(op_ready && !mem_req && !mem_lock && !done, "R11 reset state",
        {60'h0, op_ready, mem_req, mem_lock, done}, 64'h8);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 dword add with carry across halves, fetch
    mem_m[2] = 64'h0000_0001_ffff_ffff;
    run_op(8'h01, 1, 32'h10, 16'h0, 64'h1, 64'h0);
    chk(mem_m[2] == 64'h0000_0002_0000_0000, "R2 dword add carry", mem_m[2], 64'h0000_0002_0000_0000);
    // R7 word add wraps, upper half untouched, no fetch
    mem_m[3] = 64'h1234_5678_ffff_ffff;
    run_op(8'h00, 0, 32'h18, 16'h0, 64'hdead_beef_0000_0001, 64'h0);
    chk(mem_m[3] == 64'h1234_5678_0000_0000, "R7 word add wrap", mem_m[3], 64'h1234_5678_0000_0000);
    // R5 cas match dword
    mem_m[4] = 64'hcafe_0000_0000_0042;
    run_op(8'hf1, 1, 32'h20, 16'h0, 64'h5555, 64'hcafe_0000_0000_0042);
    // R5 cas miss dword
    run_op(8'hf1, 1, 32'h20, 16'h0, 64'h7777, 64'h1);
    // R7 cas word: R0 upper junk ignored
    mem_m[5] = 64'h0000_0009_0000_0000;
    run_op(8'hf1, 0, 32'h2c, 16'h0, 64'hffff_ffff_0000_0003, 64'habcd_0000_0000_0009);
    chk(mem_m[5] == 64'h0000_0003_0000_0000, "R7 word cas upper half", mem_m[5], 64'h0000_0003_0000_0000);
    // R4 exchange, negative offset (R1)
    run_op(8'he1, 1, 32'h100, 16'hffc0, 64'h0123_4567_89ab_cdef, 64'h0);
    // R10 rejected codes
    reject_op(8'h30);
    reject_op(8'h02);

    for (int i = 0; i < 300; i++) begin
      logic [3:0]  c;
      logic [31:0] d;
      logic [15:0] o;
      logic [31:0] ea;
      logic [63:0] r;
      bit dw;
      int idx;
      c  = codes[$urandom() % 6];
      dw = bit'($urandom() % 2);
      d  = $urandom();
      o  = 16'($urandom());
      ea = d + {{16{o[15]}}, o};
      d  = d - (ea & (dw ? 32'h7 : 32'h3));
      ea = d + {{16{o[15]}}, o};
      idx = int'(ea[6:3]);
      r = {$urandom(), $urandom()};
      if ($urandom() % 2 == 0)
        r = dw ? mem_m[idx] : {$urandom(), (ea[2] ? mem_m[idx][63:32] : mem_m[idx][31:0])};
      run_op({c, 3'b000, 1'($urandom() % 2)}, dw, d, o, {$urandom(), $urandom()}, r);
    end

    chk(lock_bad == 0, "R8 lock with every request", 64'(lock_bad), 64'h0);
    chk(wzext_bad == 0, "R7 word write data zero upper", 64'(wzext_bad), 64'h0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule